// File: doc/BRIEF.md
# Vector Operand Fetch and Swizzle

This block prepares the two source operands of one vector arithmetic instruction of a programmable vertex pipeline. Given two source register indices, a destination index, an address-register select and an operand descriptor, it locates each source in one of three register banks (per-vertex inputs, scratch temporaries, float constants), rearranges the four components of each fetched vector, optionally flips their signs, and registers the result together with the per-component write enables for the destination bank. Each component is a 24-bit float: sign in bit 23, a 7-bit exponent with bias 63 in bits 22:16, and a 16-bit fraction in bits 15:0. In a packed vector, component c (x=0, y=1, z=2, w=3) occupies bits 24c+23 down to 24c.

The block also keeps two signed address registers. A move-to-address instruction converts the x and y components of the prepared first operand to integers and loads them. Later instructions can then add one of them to their first source index, which gives indexed access to the constant bank. A single write port fills the three banks. The arithmetic that consumes the operands lives elsewhere.

The operand descriptor is a 22-bit word. Bits 3:0 hold the destination write mask, with bit c enabling component c. Bit 4 negates source 1. Bits 12:5 hold the source-1 selectors, and bits 21:14 hold the source-2 selectors, in each case two bits per component with component c at offset 2c. Bit 13 negates source 2.

Top module: `opf_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `resValid`, both operand outputs, both write-enable outputs, both index outputs and both address registers read zero, and every bank entry reads as zero.
- R2: `resValid` is high exactly in the cycle after a cycle with `opValid` high. The operand, enable and index outputs change only on such an edge and otherwise hold their values.
- R3: An effective source index is decoded as follows. Indices 0 to 15 select input entry i. Indices 16 to 31 select temporary i-16. Indices 32 to 127 select constant i-32. A negative index, or one above 127, yields an all-zero vector.
- R4: `addrSel` picks the offset added to the source-1 index before decoding: 1 adds address register 0, 2 adds address register 1, and 0 or 3 adds nothing. The source-2 index is never offset.
- R5: Output component c of a source equals the fetched component named by that source's 2-bit selector for c (0=x, 1=y, 2=z, 3=w). Any selector pattern, including repeats, is allowed.
- R6: When a source's negate bit is set, bit 23 of all four of its output components is inverted and no other bit changes. The two sources are negated independently.
- R7: For an arithmetic instruction, a destination index from 0 to 7 gives `outWe` equal to the write mask and `tmpWe` zero. An index from 16 to 31 gives `tmpWe` equal to the mask and `outWe` zero. Indices 8 to 15 and 32 and above give both zero. `outIdx` carries destination bits 2:0 and `tmpIdx` carries bits 3:0.
- R8: For a move-to-address instruction, both enable outputs are zero. If mask bit 0 is set, address register 0 is loaded from source-1 component x. If mask bit 1 is set, address register 1 is loaded from component y. The conversion truncates toward zero, returns 0 for magnitudes below 1, and saturates to +127 or -128 for magnitudes of 128 or more.
- R9: A bank write (`wrBank` 0=input, 1=temporary, 2=constant) takes effect at the clock edge. A fetch in the same cycle sees the old contents. `wrBank` 3 and entry indices beyond a bank's size change nothing.
- R10: An address register changes only on a move-to-address instruction. A new value first offsets the instruction issued in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | An instruction is presented this cycle |
| opMova | input | 1 | The instruction is a move-to-address |
| src1Idx | input | 7 | First source register index |
| src2Idx | input | 7 | Second source register index |
| addrSel | input | 2 | Offset select for the first source |
| dstIdx | input | 7 | Destination register index |
| opDesc | input | 22 | Operand descriptor (mask, selectors, negates) |
| wrValid | input | 1 | Bank write strobe |
| wrBank | input | 2 | Bank selected for the write |
| wrIdx | input | 7 | Entry within the selected bank |
| wrData | input | 96 | Vector written |
| resValid | output | 1 | Registered operands are fresh |
| src1Vec | output | 96 | Prepared first operand |
| src2Vec | output | 96 | Prepared second operand |
| outWe | output | 4 | Component enables into the output bank |
| outIdx | output | 3 | Output bank entry |
| tmpWe | output | 4 | Component enables into the temporary bank |
| tmpIdx | output | 4 | Temporary bank entry |
| addrReg0 | output | 8 | Address register 0 (signed) |
| addrReg1 | output | 8 | Address register 1 (signed) |

## Verification
The bench builds the block with its defaults: 16 inputs, 16 temporaries, 96 constants, 7-bit indices and 8-bit address registers. With an 8-bit address register, a modest float such as 300.0 already reaches the saturation limits. An offset of a few units pushes an effective index past 127 or below zero, so the zero-vector path and both clamp values are exercised both by directed cases and by random traffic. The full 7-bit index range reaches every bank boundary, including the discarded destination windows.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int NCOMP   = 4;
  localparam int SEL_W   = 2;
  localparam int F_MAN_W = 16;
  localparam int F_EXP_W = 7;
  localparam int COMP_W  = 1 + F_EXP_W + F_MAN_W;
  localparam int F_BIAS  = (1 << (F_EXP_W - 1)) - 1;
  localparam int VEC_W   = NCOMP * COMP_W;
  localparam int SWZ_W   = NCOMP * SEL_W;

  // descriptor layout
  localparam int D_MASK_LSB = 0;
  localparam int D_NEG1_BIT = D_MASK_LSB + NCOMP;
  localparam int D_SEL1_LSB = D_NEG1_BIT + 1;
  localparam int D_NEG2_BIT = D_SEL1_LSB + SWZ_W;
  localparam int D_SEL2_LSB = D_NEG2_BIT + 1;
  localparam int DESC_W     = D_SEL2_LSB + SWZ_W;

  typedef enum logic [1:0] {
    BANK_IN   = 2'd0,
    BANK_TMP  = 2'd1,
    BANK_UNI  = 2'd2,
    BANK_NONE = 2'd3
  } bankSel_e;

  typedef struct packed {
    logic             capture;
    logic             loadA0;
    logic             loadA1;
    logic [NCOMP-1:0] outWe;
    logic [NCOMP-1:0] tmpWe;
  } ctrlStrb_t;
endpackage

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int N_OUT = 8,
  parameter int N_IN  = 16,
  parameter int N_TMP = 16,
  localparam int OSEL_W = $clog2(N_OUT),
  localparam int TSEL_W = $clog2(N_TMP)
) (
  input  logic              opValid,
  input  logic              opMova,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [NCOMP-1:0]  wrMask,
  output ctrlStrb_t         strb,
  output logic [OSEL_W-1:0] outSel,
  output logic [TSEL_W-1:0] tmpSel
);
  localparam logic [IDX_W:0] OUT_END = (IDX_W+1)'(N_OUT);
  localparam logic [IDX_W:0] TMP_LO  = (IDX_W+1)'(N_IN);
  localparam logic [IDX_W:0] TMP_HI  = (IDX_W+1)'(N_IN + N_TMP);

  logic [IDX_W:0]   dstExt;
  logic             hitOut;
  logic             hitTmp;
  logic             isArith;
  logic [IDX_W-1:0] tmpOff;

  assign dstExt  = {1'b0, dstIdx};
  assign hitOut  = dstExt < OUT_END;
  assign hitTmp  = (dstExt >= TMP_LO) && (dstExt < TMP_HI);
  assign isArith = opValid && !opMova;
  assign tmpOff  = dstIdx - IDX_W'(N_IN);

  always_comb begin
    strb         = '0;
    strb.capture = opValid;
    strb.loadA0  = opValid && opMova && wrMask[0];
    strb.loadA1  = opValid && opMova && wrMask[1];
    strb.outWe   = (isArith && hitOut) ? wrMask : '0;
    strb.tmpWe   = (isArith && hitTmp) ? wrMask : '0;
  end

  assign outSel = dstIdx[OSEL_W-1:0];
  assign tmpSel = tmpOff[TSEL_W-1:0];
endmodule

// File: rtl/opf_datapath.sv
module opf_datapath
  import opf_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int N_OUT  = 8,
  parameter int N_IN   = 16,
  parameter int N_TMP  = 16,
  parameter int N_UNI  = 96,
  parameter int ADDR_W = 8,
  localparam int OSEL_W = $clog2(N_OUT),
  localparam int TSEL_W = $clog2(N_TMP)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrb_t         strb,
  input  logic [IDX_W-1:0]  src1Idx,
  input  logic [IDX_W-1:0]  src2Idx,
  input  logic [1:0]        addrSel,
  input  logic [DESC_W-1:0] desc,
  input  logic [OSEL_W-1:0] outSel,
  input  logic [TSEL_W-1:0] tmpSel,
  input  logic              wrValid,
  input  logic [1:0]        wrBank,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [VEC_W-1:0]  wrData,
  output logic              resValid,
  output logic [VEC_W-1:0]  src1Vec,
  output logic [VEC_W-1:0]  src2Vec,
  output logic [NCOMP-1:0]  outWe,
  output logic [OSEL_W-1:0] outIdx,
  output logic [NCOMP-1:0]  tmpWe,
  output logic [TSEL_W-1:0] tmpIdx,
  output logic [ADDR_W-1:0] addrReg0,
  output logic [ADDR_W-1:0] addrReg1
);
  localparam int IN_AW  = $clog2(N_IN);
  localparam int UNI_AW = $clog2(N_UNI);
  localparam int SUM_W  = ((IDX_W + 1 > ADDR_W) ? IDX_W + 1 : ADDR_W) + 1;
  localparam logic signed [SUM_W-1:0] L_TMP = SUM_W'(N_IN);
  localparam logic signed [SUM_W-1:0] L_UNI = SUM_W'(N_IN + N_TMP);
  localparam logic signed [SUM_W-1:0] L_END = SUM_W'(N_IN + N_TMP + N_UNI);
  localparam logic [IDX_W:0] W_IN  = (IDX_W+1)'(N_IN);
  localparam logic [IDX_W:0] W_TMP = (IDX_W+1)'(N_TMP);
  localparam logic [IDX_W:0] W_UNI = (IDX_W+1)'(N_UNI);
  localparam logic [ADDR_W-1:0] A_MAX = {1'b0, {(ADDR_W-1){1'b1}}};
  localparam logic [ADDR_W-1:0] A_MIN = {1'b1, {(ADDR_W-1){1'b0}}};

  logic [VEC_W-1:0] inBank  [N_IN];
  logic [VEC_W-1:0] tmpBank [N_TMP];
  logic [VEC_W-1:0] uniBank [N_UNI];

  logic [ADDR_W-1:0] addrA0;
  logic [ADDR_W-1:0] addrA1;

  logic signed [ADDR_W-1:0] offs;
  logic signed [SUM_W-1:0]  base1;
  logic signed [SUM_W-1:0]  offsX;
  logic [1:0][SUM_W-1:0]    effIdx;
  logic [1:0][VEC_W-1:0]    rawVec;
  logic [1:0][VEC_W-1:0]    swzVec;

  logic              resValidQ;
  logic [VEC_W-1:0]  s1Q;
  logic [VEC_W-1:0]  s2Q;
  logic [NCOMP-1:0]  outWeQ;
  logic [OSEL_W-1:0] outIdxQ;
  logic [NCOMP-1:0]  tmpWeQ;
  logic [TSEL_W-1:0] tmpIdxQ;

  // bank lookup by index window; anything outside reads zero
  function automatic logic [VEC_W-1:0] fetchVec(input logic [SUM_W-1:0] e);
    logic signed [SUM_W-1:0] se;
    logic signed [SUM_W-1:0] rel;
    logic [VEC_W-1:0]        v;
    se  = $signed(e);
    rel = '0;
    v   = '0;
    if (se < 0) begin
      v = '0;
    end else if (se < L_TMP) begin
      v = inBank[se[IN_AW-1:0]];
    end else if (se < L_UNI) begin
      rel = se - L_TMP;
      v   = tmpBank[rel[TSEL_W-1:0]];
    end else if (se < L_END) begin
      rel = se - L_UNI;
      v   = uniBank[rel[UNI_AW-1:0]];
    end
    return v;
  endfunction

  // float component to signed integer: truncate, clamp to register range
  function automatic logic [ADDR_W-1:0] f24ToInt(input logic [COMP_W-1:0] f);
    int                 ex;
    int                 k;
    logic [F_MAN_W:0]   sig;
    logic [F_MAN_W:0]   sh;
    logic [ADDR_W-1:0]  mag;
    logic [ADDR_W-1:0]  r;
    ex  = int'(f[F_MAN_W +: F_EXP_W]);
    sig = {1'b1, f[F_MAN_W-1:0]};
    sh  = '0;
    mag = '0;
    k   = 0;
    if (ex < F_BIAS) begin
      r = '0;
    end else begin
      k = ex - F_BIAS;
      if (k >= ADDR_W - 1) begin
        r = f[COMP_W-1] ? A_MIN : A_MAX;
      end else begin
        sh  = sig >> (F_MAN_W - k);
        mag = sh[ADDR_W-1:0];
        r   = f[COMP_W-1] ? (~mag + 1'b1) : mag;
      end
    end
    return r;
  endfunction

  // source index formation
  always_comb begin
    case (addrSel)
      2'd1:    offs = addrA0;
      2'd2:    offs = addrA1;
      default: offs = '0;
    endcase
  end

  assign base1     = $signed({{(SUM_W-IDX_W){1'b0}}, src1Idx});
  assign offsX     = {{(SUM_W-ADDR_W){offs[ADDR_W-1]}}, offs};
  assign effIdx[0] = base1 + offsX;
  assign effIdx[1] = {{(SUM_W-IDX_W){1'b0}}, src2Idx};

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      rawVec[s] = fetchVec(effIdx[s]);
    end
  end

  // per-source, per-component select and sign flip
  for (genvar s = 0; s < 2; s++) begin : g_src
    localparam int SL = (s == 0) ? D_SEL1_LSB : D_SEL2_LSB;
    localparam int NB = (s == 0) ? D_NEG1_BIT : D_NEG2_BIT;
    for (genvar c = 0; c < NCOMP; c++) begin : g_comp
      logic [SEL_W-1:0]  pick;
      logic [COMP_W-1:0] picked;
      assign pick   = desc[SL + c*SEL_W +: SEL_W];
      assign picked = rawVec[s][int'(pick)*COMP_W +: COMP_W];
      assign swzVec[s][c*COMP_W +: COMP_W] = picked ^ {desc[NB], {(COMP_W-1){1'b0}}};
    end
  end

  // operand and destination registers
  always_ff @(posedge clk) begin
    if (rst) begin
      resValidQ <= 1'b0;
      s1Q       <= '0;
      s2Q       <= '0;
      outWeQ    <= '0;
      outIdxQ   <= '0;
      tmpWeQ    <= '0;
      tmpIdxQ   <= '0;
    end else begin
      resValidQ <= strb.capture;
      if (strb.capture) begin
        s1Q     <= swzVec[0];
        s2Q     <= swzVec[1];
        outWeQ  <= strb.outWe;
        outIdxQ <= outSel;
        tmpWeQ  <= strb.tmpWe;
        tmpIdxQ <= tmpSel;
      end
    end
  end

  // address registers
  always_ff @(posedge clk) begin
    if (rst) begin
      addrA0 <= '0;
      addrA1 <= '0;
    end else begin
      if (strb.loadA0) addrA0 <= f24ToInt(swzVec[0][0 +: COMP_W]);
      if (strb.loadA1) addrA1 <= f24ToInt(swzVec[0][COMP_W +: COMP_W]);
    end
  end

  // bank write port
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_IN; i++)  inBank[i]  <= '0;
      for (int i = 0; i < N_TMP; i++) tmpBank[i] <= '0;
      for (int i = 0; i < N_UNI; i++) uniBank[i] <= '0;
    end else if (wrValid) begin
      case (bankSel_e'(wrBank))
        BANK_IN:  if ({1'b0, wrIdx} < W_IN)  inBank[wrIdx[IN_AW-1:0]]   <= wrData;
        BANK_TMP: if ({1'b0, wrIdx} < W_TMP) tmpBank[wrIdx[TSEL_W-1:0]] <= wrData;
        BANK_UNI: if ({1'b0, wrIdx} < W_UNI) uniBank[wrIdx[UNI_AW-1:0]] <= wrData;
        default: ;
      endcase
    end
  end

  assign resValid = resValidQ;
  assign src1Vec  = s1Q;
  assign src2Vec  = s2Q;
  assign outWe    = outWeQ;
  assign outIdx   = outIdxQ;
  assign tmpWe    = tmpWeQ;
  assign tmpIdx   = tmpIdxQ;
  assign addrReg0 = addrA0;
  assign addrReg1 = addrA1;
endmodule

// File: rtl/opf_top.sv
module opf_top
  import opf_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int N_OUT  = 8,
  parameter int N_IN   = 16,
  parameter int N_TMP  = 16,
  parameter int N_UNI  = 96,
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       opValid,
  input  logic                       opMova,
  input  logic [IDX_W-1:0]           src1Idx,
  input  logic [IDX_W-1:0]           src2Idx,
  input  logic [1:0]                 addrSel,
  input  logic [IDX_W-1:0]           dstIdx,
  input  logic [DESC_W-1:0]          opDesc,
  input  logic                       wrValid,
  input  logic [1:0]                 wrBank,
  input  logic [IDX_W-1:0]           wrIdx,
  input  logic [VEC_W-1:0]           wrData,
  output logic                       resValid,
  output logic [VEC_W-1:0]           src1Vec,
  output logic [VEC_W-1:0]           src2Vec,
  output logic [NCOMP-1:0]           outWe,
  output logic [$clog2(N_OUT)-1:0]   outIdx,
  output logic [NCOMP-1:0]           tmpWe,
  output logic [$clog2(N_TMP)-1:0]   tmpIdx,
  output logic [ADDR_W-1:0]          addrReg0,
  output logic [ADDR_W-1:0]          addrReg1
);
  ctrlStrb_t                  strb;
  logic [$clog2(N_OUT)-1:0]   outSel;
  logic [$clog2(N_TMP)-1:0]   tmpSel;

  opf_ctrl #(
    .IDX_W(IDX_W), .N_OUT(N_OUT), .N_IN(N_IN), .N_TMP(N_TMP)
  ) u_ctrl (
    .opValid (opValid),
    .opMova  (opMova),
    .dstIdx  (dstIdx),
    .wrMask  (opDesc[D_MASK_LSB +: NCOMP]),
    .strb    (strb),
    .outSel  (outSel),
    .tmpSel  (tmpSel)
  );

  opf_datapath #(
    .IDX_W(IDX_W), .N_OUT(N_OUT), .N_IN(N_IN), .N_TMP(N_TMP),
    .N_UNI(N_UNI), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .src1Idx  (src1Idx),
    .src2Idx  (src2Idx),
    .addrSel  (addrSel),
    .desc     (opDesc),
    .outSel   (outSel),
    .tmpSel   (tmpSel),
    .wrValid  (wrValid),
    .wrBank   (wrBank),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .resValid (resValid),
    .src1Vec  (src1Vec),
    .src2Vec  (src2Vec),
    .outWe    (outWe),
    .outIdx   (outIdx),
    .tmpWe    (tmpWe),
    .tmpIdx   (tmpIdx),
    .addrReg0 (addrReg0),
    .addrReg1 (addrReg1)
  );
endmodule

// File: rtl/opf_checker.sv
module opf_checker
  import opf_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int N_OUT  = 8,
  parameter int N_IN   = 16,
  parameter int N_TMP  = 16,
  parameter int ADDR_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               opValid,
  input logic               opMova,
  input logic [IDX_W-1:0]   dstIdx,
  input logic [DESC_W-1:0]  opDesc,
  input logic               resValid,
  input logic [VEC_W-1:0]   src1Vec,
  input logic [VEC_W-1:0]   src2Vec,
  input logic [NCOMP-1:0]   outWe,
  input logic [NCOMP-1:0]   tmpWe,
  input logic [ADDR_W-1:0]  addrReg0,
  input logic [ADDR_W-1:0]  addrReg1
);
  logic dstDiscard;
  assign dstDiscard = ((int'(dstIdx) >= N_OUT) && (int'(dstIdx) < N_IN)) ||
                      (int'(dstIdx) >= N_IN + N_TMP);

  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!resValid && addrReg0 == '0 && addrReg1 == '0));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    opValid |=> resValid);

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> (!resValid && $stable(src1Vec) && $stable(src2Vec)));

  p_discard_r7: assert property (@(posedge clk) disable iff (rst)
    (opValid && !opMova && dstDiscard) |=> (outWe == '0 && tmpWe == '0));

  p_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (opValid && !opMova) |=> (((outWe | tmpWe) & ~$past(opDesc[D_MASK_LSB +: NCOMP])) == '0));

  p_one_bank_r7: assert property (@(posedge clk) disable iff (rst)
    resValid |-> !((|outWe) && (|tmpWe)));

  p_mova_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
    (opValid && opMova) |=> (outWe == '0 && tmpWe == '0));

  p_mova_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (opValid && opMova && !opDesc[D_MASK_LSB]) |=> $stable(addrReg0));

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(opValid && opMova) |=> ($stable(addrReg0) && $stable(addrReg1)));
endmodule

bind opf_top opf_checker #(
  .IDX_W(IDX_W), .N_OUT(N_OUT), .N_IN(N_IN), .N_TMP(N_TMP), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/opf_top_tb.sv
module opf_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic        opMova = 1'b0;
  logic [6:0]  src1Idx = '0;
  logic [6:0]  src2Idx = '0;
  logic [1:0]  addrSel = '0;
  logic [6:0]  dstIdx = '0;
  logic [21:0] opDesc = '0;
  logic        wrValid = 1'b0;
  logic [1:0]  wrBank = '0;
  logic [6:0]  wrIdx = '0;
  logic [95:0] wrData = '0;
  logic        resValid;
  logic [95:0] src1Vec, src2Vec;
  logic [3:0]  outWe, tmpWe;
  logic [2:0]  outIdx;
  logic [3:0]  tmpIdx;
  logic [7:0]  addrReg0, addrReg1;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    done = 0;

  always #10 clk = ~clk;

  opf_top u_dut (
    .clk(clk), .rst(rst), .opValid(opValid), .opMova(opMova),
    .src1Idx(src1Idx), .src2Idx(src2Idx), .addrSel(addrSel), .dstIdx(dstIdx),
    .opDesc(opDesc), .wrValid(wrValid), .wrBank(wrBank), .wrIdx(wrIdx),
    .wrData(wrData), .resValid(resValid), .src1Vec(src1Vec), .src2Vec(src2Vec),
    .outWe(outWe), .outIdx(outIdx), .tmpWe(tmpWe), .tmpIdx(tmpIdx),
    .addrReg0(addrReg0), .addrReg1(addrReg1)
  );

  // ---------------- reference model ----------------
  logic [95:0] mIn [16];
  logic [95:0] mTmp[16];
  logic [95:0] mUni[96];
  int          ma0, ma1;
  logic        eValid;
  logic [95:0] eS1, eS2;
  logic [3:0]  eOutWe, eTmpWe;
  logic [2:0]  eOutIdx;
  logic [3:0]  eTmpIdx;

  function automatic logic [95:0] mFetch(int e);
    if (e < 0 || e > 127) return '0;
    if (e < 16) return mIn[e];
    if (e < 32) return mTmp[e-16];
    return mUni[e-32];
  endfunction

  function automatic logic [95:0] mSwz(logic [95:0] v, logic [7:0] sel, logic neg);
    logic [95:0] r;
    for (int c = 0; c < 4; c++) begin
      int s;
      s = int'(sel[2*c +: 2]);
      r[24*c +: 24] = v[24*s +: 24];
      if (neg) r[24*c+23] = ~r[24*c+23];
    end
    return r;
  endfunction

  function automatic int mCvt(logic [23:0] f);
    int e, k, r;
    e = int'(f[22:16]);
    if (e < 63) return 0;
    k = e - 63;
    if (k >= 7) return f[23] ? -128 : 127;
    r = (65536 + int'(f[15:0])) >> (16 - k);
    return f[23] ? -r : r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) begin mIn[i] = '0; mTmp[i] = '0; end
      for (int i = 0; i < 96; i++) mUni[i] = '0;
      ma0 = 0; ma1 = 0;
      eValid = 0; eS1 = '0; eS2 = '0;
      eOutWe = '0; eTmpWe = '0; eOutIdx = '0; eTmpIdx = '0;
    end else begin
      eValid = opValid;
      if (opValid) begin
        int off, d, n0, n1;
        off = (addrSel == 2'd1) ? ma0 : (addrSel == 2'd2) ? ma1 : 0;
        eS1 = mSwz(mFetch(int'(src1Idx) + off), opDesc[12:5], opDesc[4]);
        eS2 = mSwz(mFetch(int'(src2Idx)), opDesc[21:14], opDesc[13]);
        d = int'(dstIdx);
        eOutIdx = dstIdx[2:0];
        eTmpIdx = dstIdx[3:0];
        eOutWe = '0; eTmpWe = '0;
        if (!opMova) begin
          if (d < 8) eOutWe = opDesc[3:0];
          else if (d >= 16 && d < 32) eTmpWe = opDesc[3:0];
        end else begin
          n0 = mCvt(eS1[23:0]);
          n1 = mCvt(eS1[47:24]);
          if (opDesc[0]) ma0 = n0;
          if (opDesc[1]) ma1 = n1;
        end
      end
      if (wrValid) begin
        if (wrBank == 2'd0 && wrIdx < 16) mIn[wrIdx] = wrData;
        else if (wrBank == 2'd1 && wrIdx < 16) mTmp[wrIdx] = wrData;
        else if (wrBank == 2'd2 && wrIdx < 96) mUni[wrIdx] = wrData;
      end
    end
  end

  task automatic chk(string what, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      int e0, e1;
      e0 = ma0 & 255;
      e1 = ma1 & 255;
      chk("resValid", 96'(resValid), 96'(eValid));
      chk("src1Vec", src1Vec, eS1);
      chk("src2Vec", src2Vec, eS2);
      chk("outWe", 96'(outWe), 96'(eOutWe));
      chk("tmpWe", 96'(tmpWe), 96'(eTmpWe));
      chk("outIdx", 96'(outIdx), 96'(eOutIdx));
      chk("tmpIdx", 96'(tmpIdx), 96'(eTmpIdx));
      chk("addrReg0", 96'(addrReg0), 96'(e0[7:0]));
      chk("addrReg1", 96'(addrReg1), 96'(e1[7:0]));
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [21:0] mkDesc(logic [3:0] mask, logic [7:0] s1, logic n1,
                                         logic [7:0] s2, logic n2);
    return {s2, n2, s1, n1, mask};
  endfunction

  task automatic issue(logic mova, logic [6:0] a, logic [6:0] b, logic [1:0] as,
                       logic [6:0] dst, logic [21:0] dsc);
    @(posedge clk); #2;
    opValid = 1; opMova = mova; src1Idx = a; src2Idx = b; addrSel = as;
    dstIdx = dst; opDesc = dsc; wrValid = 0;
  endtask

  task automatic wr(logic [1:0] bk, logic [6:0] idx, logic [95:0] data);
    @(posedge clk); #2;
    opValid = 0; opMova = 0; wrValid = 1; wrBank = bk; wrIdx = idx; wrData = data;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      opValid = 0; opMova = 0; wrValid = 0;
    end
  endtask

  function automatic logic [95:0] rnd96();
    return {$urandom, $urandom, $urandom};
  endfunction

  localparam logic [7:0] ID  = 8'hE4;
  localparam logic [7:0] REV = 8'h1B;

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    // R1: reset state seen at the ports
    @(negedge clk);
    curReq = "R1";
    chk("R1 resValid", 96'(resValid), 96'd0);
    chk("R1 addrReg0", 96'(addrReg0), 96'd0);
    chk("R1 src1Vec", src1Vec, '0);
    issue(0, 7'h05, 7'h13, 2'd0, 7'h00, mkDesc(4'hF, ID, 0, ID, 0));
    idle(1);

    curReq = "R9";
    for (int i = 0; i < 16; i++) wr(2'd0, 7'(i), rnd96());
    for (int i = 0; i < 16; i++) wr(2'd1, 7'(i), rnd96());
    for (int i = 2; i < 96; i++) wr(2'd2, 7'(i), rnd96());
    wr(2'd2, 7'd0, {24'h3E0000, 24'h470000 | 24'd11264, 24'hC10000 | 24'd24576,
                    24'h400000 | 24'd57344});
    wr(2'd2, 7'd1, {24'h0, 24'h0, 24'hC00000 | 24'd32768, 24'h410000 | 24'd16384});
    wr(2'd3, 7'd4, rnd96());
    wr(2'd1, 7'd100, rnd96());
    wr(2'd2, 7'd97, rnd96());
    idle(1);

    curReq = "R3";
    issue(0, 7'h05, 7'h13, 2'd0, 7'h02, mkDesc(4'hF, ID, 0, ID, 0));
    issue(0, 7'h20, 7'h7F, 2'd0, 7'h12, mkDesc(4'h5, ID, 0, ID, 0));
    issue(0, 7'h0F, 7'h10, 2'd0, 7'h30, mkDesc(4'hF, ID, 0, ID, 0));
    issue(0, 7'h1F, 7'h21, 2'd0, 7'h07, mkDesc(4'hA, ID, 0, ID, 0));

    curReq = "R2";
    idle(3);

    curReq = "R5";
    issue(0, 7'h20, 7'h03, 2'd0, 7'h01, mkDesc(4'hF, REV, 0, 8'h00, 0));
    issue(0, 7'h20, 7'h03, 2'd0, 7'h01, mkDesc(4'hF, 8'hFF, 0, 8'h55, 0));
    issue(0, 7'h44, 7'h18, 2'd0, 7'h01, mkDesc(4'hF, 8'h8D, 0, 8'h72, 0));

    curReq = "R6";
    issue(0, 7'h20, 7'h20, 2'd0, 7'h01, mkDesc(4'hF, ID, 1, ID, 0));
    issue(0, 7'h20, 7'h20, 2'd0, 7'h01, mkDesc(4'hF, ID, 0, REV, 1));
    issue(0, 7'h31, 7'h09, 2'd0, 7'h01, mkDesc(4'hF, ID, 1, ID, 1));

    curReq = "R7";
    issue(0, 7'h03, 7'h03, 2'd0, 7'h03, mkDesc(4'h9, ID, 0, ID, 0));
    issue(0, 7'h03, 7'h03, 2'd0, 7'h0A, mkDesc(4'hF, ID, 0, ID, 0));
    issue(0, 7'h03, 7'h03, 2'd0, 7'h15, mkDesc(4'h6, ID, 0, ID, 0));
    issue(0, 7'h03, 7'h03, 2'd0, 7'h1F, mkDesc(4'hF, ID, 0, ID, 0));
    issue(0, 7'h03, 7'h03, 2'd0, 7'h20, mkDesc(4'hF, ID, 0, ID, 0));
    issue(0, 7'h03, 7'h03, 2'd0, 7'h7F, mkDesc(4'hF, ID, 0, ID, 0));

    curReq = "R8";
    issue(1, 7'h20, 7'h00, 2'd0, 7'h00, mkDesc(4'h3, ID, 0, ID, 0));     // 3, -5
    issue(1, 7'h20, 7'h00, 2'd0, 7'h00, mkDesc(4'h1, 8'h0E, 0, ID, 0));  // +300 -> 127
    issue(1, 7'h20, 7'h00, 2'd0, 7'h10, mkDesc(4'h1, 8'h02, 1, ID, 0));  // -300 -> -128
    issue(1, 7'h20, 7'h00, 2'd0, 7'h00, mkDesc(4'h2, 8'h0C, 0, ID, 0));  // 0.5 -> 0
    issue(1, 7'h20, 7'h00, 2'd0, 7'h00, mkDesc(4'h0, ID, 0, ID, 0));     // gated off
    idle(1);

    curReq = "R10";
    issue(1, 7'h21, 7'h00, 2'd0, 7'h00, mkDesc(4'h3, ID, 0, ID, 0));     // a0=5, a1=-3
    issue(0, 7'h10, 7'h10, 2'd1, 7'h00, mkDesc(4'hF, ID, 0, ID, 0));     // sees new a0

    curReq = "R4";
    issue(0, 7'h10, 7'h10, 2'd2, 7'h00, mkDesc(4'hF, ID, 0, ID, 0));
    issue(0, 7'h10, 7'h10, 2'd3, 7'h00, mkDesc(4'hF, ID, 0, ID, 0));
    issue(0, 7'h7D, 7'h7D, 2'd1, 7'h00, mkDesc(4'hF, ID, 0, ID, 0));     // 130 -> zero
    issue(0, 7'h01, 7'h01, 2'd2, 7'h00, mkDesc(4'hF, ID, 0, ID, 0));     // -2 -> zero
    issue(0, 7'h1B, 7'h1B, 2'd1, 7'h00, mkDesc(4'hF, ID, 0, ID, 0));     // 32 -> constant 0

    curReq = "R9";
    @(posedge clk); #2;
    opValid = 1; opMova = 0; src1Idx = 7'h13; src2Idx = 7'h03; addrSel = 0;
    dstIdx = 0; opDesc = mkDesc(4'hF, ID, 0, ID, 0);
    wrValid = 1; wrBank = 2'd1; wrIdx = 7'd3; wrData = rnd96();
    issue(0, 7'h13, 7'h03, 2'd0, 7'h00, mkDesc(4'hF, ID, 0, ID, 0));
    idle(2);

    curReq = "R3";
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk); #2;
      opValid = ($urandom % 4) != 0;
      opMova  = ($urandom % 8) == 0;
      src1Idx = 7'($urandom);
      src2Idx = 7'($urandom);
      addrSel = 2'($urandom);
      dstIdx  = 7'($urandom);
      opDesc  = 22'($urandom);
      wrValid = ($urandom % 3) == 0;
      wrBank  = 2'($urandom);
      wrIdx   = 7'($urandom);
      wrData  = rnd96();
    end
    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog %s actual=timeout expected=completion", curReq);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule